// File: doc/BRIEF.md
# Interrupt Event Status Controller

This unit collects a peripheral's interrupt conditions into a pending-status word. It lets software choose which pending conditions raise an event. One input line per condition sets a sticky pending bit. A mask word gates those bits into a masked view, and any masked bit that is pending drives an event request toward the system.

Software reaches the unit through a small register port, and it has five ways to work with the pending bits:

- read the raw view;
- read the masked view;
- force bits for diagnostics;
- clear bits;
- read a priority index, which also retires the most urgent masked bit.

A hardware consumer can instead service the event through a four-phase request/acknowledge handshake. The rising acknowledge retires the most urgent masked bit in the same way.

Top module: `irq_event_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every pending bit and every mask bit is zero, `evt_req` is low, and `bus_rdata` is zero.
- R2: A condition input held high at a clock edge sets its pending bit at that edge. The bit stays set after the input falls. The raw pending word reads at offset 0x00.
- R3: The mask word is written and read at offset 0x04, and a 1 unmasks a condition. Offset 0x08 reads the raw pending word ANDed with the mask.
- R4: A write to offset 0x0C sets each pending bit whose data bit is 1 and leaves bits written 0 unchanged. A read of 0x0C returns zero.
- R5: A write to offset 0x10 clears each pending bit whose data bit is 1. A bit whose condition input is high in that cycle stays set. A read of 0x10 returns zero.
- R6: A read of offset 0x14 returns 0 when the masked word is zero. Otherwise it returns the lowest set masked bit position plus one, so bit 0 has the highest priority.
- R7: A read of offset 0x14 clears the pending bit whose index it returns, unless that bit's condition input is high in the same cycle.
- R8: `evt_req` rises one cycle after the masked word is nonzero while `evt_ack` is low. Once high, it stays high until `evt_ack` is seen high.
- R9: The first cycle with `evt_req` and `evt_ack` both high clears the highest-priority masked pending bit and drops `evt_req`. `evt_req` does not rise again until `evt_ack` has been seen low.
- R10: Read data appears on `bus_rdata` one cycle after the read request. Writes to the read-only offsets 0x00, 0x08 and 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | N | Condition inputs, one per pending bit |
| bus_valid | input | 1 | Register access request for this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after the read |
| evt_req | output | 1 | Event request of the handshake |
| evt_ack | input | 1 | Event acknowledge of the handshake |

## Verification
The handshake assertions assume the consumer follows four-phase order. They expect `evt_ack` to rise only while `evt_req` is high, or to be pulsed while no request is outstanding. The directed stimulus raises `evt_ack` only in those situations and always lowers it before expecting a new request.

The set-bit and condition-input assertions assume `N` does not exceed the data width, which the default parameters respect. Bus requests are driven away from the clock edge and held for exactly one cycle, so each access is seen once.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int N  = 8,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  src,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          evt_req,
  input  logic          evt_ack
);
  localparam int IW = $clog2(N + 1);
  localparam logic [AW-1:0] OFS_RAW  = AW'('h00);
  localparam logic [AW-1:0] OFS_MASK = AW'('h04);
  localparam logic [AW-1:0] OFS_MSK  = AW'('h08);
  localparam logic [AW-1:0] OFS_SET  = AW'('h0C);
  localparam logic [AW-1:0] OFS_CLR  = AW'('h10);
  localparam logic [AW-1:0] OFS_IDX  = AW'('h14);

  logic [N-1:0]  raw_q, mask_q, mis, top_hot, set_v, clr_v;
  logic [IW-1:0] top_idx;
  logic [DW-1:0] rd_d;
  logic          req_q, rd, wr, serviced;

  assign rd       = bus_valid & ~bus_write;
  assign wr       = bus_valid & bus_write;
  assign mis      = raw_q & mask_q;
  assign serviced = req_q & evt_ack;
  assign evt_req  = req_q;

  always_comb begin
    top_idx = '0;
    top_hot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mis[i]) begin
        top_idx    = IW'(i + 1);
        top_hot    = '0;
        top_hot[i] = 1'b1;
      end
    end
  end

  assign set_v = (wr && bus_addr == OFS_SET) ? bus_wdata[N-1:0] : '0;
  assign clr_v = ((wr && bus_addr == OFS_CLR) ? bus_wdata[N-1:0] : '0)
               | ((rd && bus_addr == OFS_IDX) ? top_hot : '0)
               | (serviced ? top_hot : '0);

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      OFS_RAW:  rd_d = DW'(raw_q);
      OFS_MASK: rd_d = DW'(mask_q);
      OFS_MSK:  rd_d = DW'(mis);
      OFS_IDX:  rd_d = DW'(top_idx);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= '0;
      mask_q    <= '0;
      req_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_v) | src | set_v;
      if (wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[N-1:0];
      if (rd) bus_rdata <= rd_d;
      if (serviced) req_q <= 1'b0;
      else if (!req_q && !evt_ack && |mis) req_q <= 1'b1;
    end
  end

  a_r2_src_sets: assert property (@(posedge clk) disable iff (rst)
    |src |=> ((raw_q & $past(src)) == $past(src)));

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFS_SET) |=>
      ((raw_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

  a_r6_idle_index: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == OFS_IDX && mis == '0) |=> (bus_rdata == '0));

  a_r8_req_holds: assert property (@(posedge clk) disable iff (rst)
    (evt_req && !evt_ack) |=> evt_req);

  a_r9_req_drops: assert property (@(posedge clk) disable iff (rst)
    (evt_req && evt_ack) |=> !evt_req);

  a_r9_no_early_req: assert property (@(posedge clk) disable iff (rst)
    (!evt_req && evt_ack) |=> !evt_req);

  a_r10_ro_write: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFS_MSK && src == '0 && !serviced) |=>
      (raw_q == $past(raw_q)) && (mask_q == $past(mask_q)));
endmodule

// File: tb/sim_irq_event_ctrl.sv
`timescale 1ns/1ps
module sim_irq_event_ctrl;
  logic        clk = 0, rst = 1;
  logic [7:0]  src = 0;
  logic        bus_valid = 0, bus_write = 0, evt_ack = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        evt_req;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  irq_event_ctrl #(.N(8), .AW(5), .DW(32)) u0 (
    .clk(clk), .rst(rst), .src(src), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_req(evt_req), .evt_ack(evt_ack));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 req", {31'b0, evt_req}, 0);
    rd(5'h00, v); chk("R1 raw", v, 0);
    rd(5'h04, v); chk("R1 mask", v, 0);
    rd(5'h14, v); chk("R1 index", v, 0);
  endtask

  task automatic t_source;
    @(negedge clk); src = 8'h08;
    @(negedge clk); src = 8'h00;
    rd(5'h00, v); chk("R2 raw sticky", v, 32'h08);
    rd(5'h08, v); chk("R3 masked zero", v, 0);
    chk("R8 no req when masked", {31'b0, evt_req}, 0);
  endtask

  task automatic t_mask;
    wr(5'h04, 32'h0A);
    rd(5'h04, v); chk("R3 mask readback", v, 32'h0A);
    rd(5'h08, v); chk("R3 masked and", v, 32'h08);
  endtask

  task automatic t_set;
    wr(5'h0C, 32'h05);
    rd(5'h00, v); chk("R4 set bits", v, 32'h0D);
    wr(5'h0C, 32'h00);
    rd(5'h00, v); chk("R4 zero write", v, 32'h0D);
    rd(5'h0C, v); chk("R4 reads zero", v, 0);
    rd(5'h08, v); chk("R3 masked after set", v, 32'h08);
    wr(5'h04, 32'hFF);
    rd(5'h08, v); chk("R3 full mask", v, 32'h0D);
  endtask

  task automatic t_index;
    rd(5'h14, v); chk("R6 index bit0", v, 1);
    rd(5'h00, v); chk("R7 cleared bit0", v, 32'h0C);
    rd(5'h14, v); chk("R6 index bit2", v, 3);
    rd(5'h14, v); chk("R6 index bit3", v, 4);
    rd(5'h00, v); chk("R7 all cleared", v, 0);
    rd(5'h14, v); chk("R6 empty index", v, 0);
  endtask

  task automatic t_clear;
    wr(5'h0C, 32'h30);
    wr(5'h10, 32'h10);
    rd(5'h00, v); chk("R5 clear", v, 32'h20);
    @(negedge clk); src = 8'h20;
    wr(5'h10, 32'h20);
    rd(5'h00, v); chk("R5 clear blocked", v, 32'h20);
    rd(5'h14, v); chk("R6 index bit5", v, 6);
    rd(5'h00, v); chk("R7 index clear blocked", v, 32'h20);
    @(negedge clk); src = 8'h00;
    wr(5'h10, 32'h20);
    rd(5'h00, v); chk("R5 clear after release", v, 0);
    rd(5'h10, v); chk("R5 reads zero", v, 0);
  endtask

  task automatic t_readonly;
    wr(5'h00, 32'hFF);
    wr(5'h08, 32'hFF);
    wr(5'h14, 32'hFF);
    rd(5'h00, v); chk("R10 ro writes ignored", v, 0);
    rd(5'h04, v); chk("R10 mask untouched", v, 32'hFF);
  endtask

  task automatic t_handshake;
    @(negedge clk); evt_ack = 1;
    @(negedge clk); evt_ack = 0;
    @(negedge clk);
    chk("R9 stale req retired", {31'b0, evt_req}, 0);
    wr(5'h0C, 32'h06);
    @(negedge clk);
    chk("R8 req raised", {31'b0, evt_req}, 1);
    @(negedge clk);
    chk("R8 req held", {31'b0, evt_req}, 1);
    evt_ack = 1;
    @(negedge clk);
    chk("R9 req dropped", {31'b0, evt_req}, 0);
    rd(5'h00, v); chk("R9 ack cleared bit1", v, 32'h04);
    chk("R9 no req while ack", {31'b0, evt_req}, 0);
    evt_ack = 0;
    @(negedge clk);
    chk("R8 req again", {31'b0, evt_req}, 1);
    evt_ack = 1;
    @(negedge clk);
    evt_ack = 0;
    rd(5'h00, v); chk("R9 ack cleared bit2", v, 0);
    @(negedge clk);
    chk("R8 no req when empty", {31'b0, evt_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_source;
    t_mask;
    t_set;
    t_index;
    t_clear;
    t_readonly;
    t_handshake;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule